// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This block is the arithmetic and logic unit of a small eight-bit core. Each cycle it takes an operation code, two operand bytes and the core's current condition flags (half-carry H, negative N, zero Z, carry C). It computes a result byte, a high byte that only the multiply uses, and an updated flag nibble. Each flag has its own write enable. Separate write enables mark whether the result and the high byte are meant to be stored. The carry flag on the input is the carry-in for add-with-carry, subtract-with-carry and the two rotates.

All outputs are registered once, so every result appears one clock after its operands. Register storage and operand fetch belong to the surrounding core. A flag whose enable is low is passed through from the flag input unchanged, so the core can store the flag nibble as a whole. Unassigned operation codes write nothing.

Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 bit test, 9 complement, 10 negate, 11 increment, 12 decrement, 13 logical left shift, 14 logical right shift, 15 arithmetic right shift, 16 rotate left through carry, 17 rotate right through carry, 18 nibble swap, 19 test, 20 clear, 21 multiply. Codes 22 to 31 are unassigned. The flag nibble is ordered H=bit 3, N=bit 2, Z=bit 1, C=bit 0 on `flags_i`, `flags_o` and `flag_we_o`.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. The values for the operands present at a rising edge appear after that edge. While `rst_n` is low, every output is zero.
- R2: Add (0) and add with carry (1) give (A+B+cin) mod 256, where cin is `flags_i[0]` for code 1 and 0 for code 0. C is the carry out of bit 7 and H is the carry out of bit 3. All four flag enables and `res_we_o` are high.
- R3: Subtract (2), subtract with borrow (3) and compare (4) give (A-B-bin) mod 256, where bin is `flags_i[0]` for code 3 and 0 otherwise. C is set when a borrow occurs. N, Z and C are written and H is not. Compare holds `res_we_o` low.
- R4: Whenever N or Z is written, N equals bit 7 of `res_o` and Z is 1 exactly when `res_o` is zero.
- R5: AND (5), OR (6) and XOR (7) write the bitwise result and only N and Z. Bit test (8) gives A AND B on `res_o`, writes only N and Z, and holds `res_we_o` low.
- R6: Complement (9) gives A XOR 0xFF and writes C=1. Negate (10) gives (0-A) mod 256 and writes C=1 if the result is nonzero and C=0 if it is zero. Both write N and Z but not H.
- R7: Increment (11) and decrement (12) give A+1 and A-1 mod 256 and write only N and Z.
- R8: Logical left shift (13) shifts in 0 and puts old bit 7 in C. Logical right shift (14) shifts in 0 and puts old bit 0 in C. Arithmetic right shift (15) keeps bit 7 and puts old bit 0 in C. N, Z and C are written.
- R9: Rotate left (16) puts old C in bit 0 and old bit 7 in C. Rotate right (17) puts old C in bit 7 and old bit 0 in C. N, Z and C are written.
- R10: Swap (18) exchanges the nibbles of A. Test (19) shows A on `res_o` with `res_we_o` low. Clear (20) gives 0 with N=0 and Z=1. All three write only N and Z.
- R11: Multiply (21) gives the unsigned product A*B, with the low byte on `res_o` and the high byte on `hi_o`. `res_we_o` and `hi_we_o` are high. It writes H=0 and C=0 and leaves N and Z unwritten. For every other code `hi_o` and `hi_we_o` are zero.
- R12: Unassigned codes (22 to 31) drive all enables low and `res_o` zero.
- R13: Every flag whose enable is low shows the matching bit of `flags_i` on `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Operand A (accumulator side) |
| opb_i | input | 8 | Operand B |
| flags_i | input | 4 | Current flags {H,N,Z,C}; C is also carry-in |
| res_o | output | 8 | Result byte (product low byte for multiply) |
| hi_o | output | 8 | Product high byte |
| res_we_o | output | 1 | Result should be stored |
| hi_we_o | output | 1 | High byte should be stored |
| flags_o | output | 4 | Updated flags {H,N,Z,C} |
| flag_we_o | output | 4 | Per-flag write enables {H,N,Z,C} |

## Verification
Every result is due exactly one rising edge after its operands. The scoreboard drives stimulus on the falling edge and queues the expected item at that moment. The monitor pops and compares 2 ns after each following rising edge, so each queued item meets the output that register stage produced for it. The expected items come from a bench model written separately from the RTL. The stimulus includes the carry, half-carry, borrow, zero-negate and full-scale multiply corners, then a long pseudo-random sweep over every operation code.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;
    localparam int FLG_W  = 4;
    // flag nibble positions
    localparam int F_H = 3;
    localparam int F_N = 2;
    localparam int F_Z = 1;
    localparam int F_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
        OP_BTST = 5'd8,  OP_CPL  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_SLL  = 5'd13, OP_SRL  = 5'd14, OP_SRA  = 5'd15,
        OP_RLC  = 5'd16, OP_RRC  = 5'd17, OP_SWAP = 5'd18, OP_TST  = 5'd19,
        OP_CLR  = 5'd20, OP_MUL  = 5'd21
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] hi;
        logic              h;
        logic              c;
        logic [FLG_W-1:0]  fwe;
        logic              res_we;
        logic              hi_we;
    } unit_out_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output unit_out_t         o
);
    logic              cy;
    logic [DATA_W:0]   wide;
    logic [NIB_W:0]    half;
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        o    = '0;
        cy   = 1'b0;
        wide = '0;
        half = '0;
        prod = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                cy    = (op == OP_ADC) ? cin : 1'b0;
                wide  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cy};
                half  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cy};
                o.res = wide[DATA_W-1:0];
                o.c   = wide[DATA_W];
                o.h   = half[NIB_W];
                o.fwe = 4'b1111;
                o.res_we = 1'b1;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                cy    = (op == OP_SBC) ? cin : 1'b0;
                wide  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cy};
                o.res = wide[DATA_W-1:0];
                o.c   = wide[DATA_W];
                o.fwe = 4'b0111;
                o.res_we = (op != OP_CMP);
            end
            OP_NEG: begin
                o.res = '0 - a;
                o.c   = (a != '0);
                o.fwe = 4'b0111;
                o.res_we = 1'b1;
            end
            OP_INC, OP_DEC: begin
                o.res = (op == OP_INC) ? a + 1'b1 : a - 1'b1;
                o.fwe = 4'b0110;
                o.res_we = 1'b1;
            end
            OP_MUL: begin
                prod  = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
                o.res = prod[DATA_W-1:0];
                o.hi  = prod[2*DATA_W-1:DATA_W];
                o.fwe = 4'b1001;
                o.res_we = 1'b1;
                o.hi_we  = 1'b1;
            end
            default: o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output unit_out_t         o
);
    always_comb begin
        o = '0;
        unique case (op)
            OP_AND:  begin o.res = a & b; o.fwe = 4'b0110; o.res_we = 1'b1; end
            OP_OR:   begin o.res = a | b; o.fwe = 4'b0110; o.res_we = 1'b1; end
            OP_XOR:  begin o.res = a ^ b; o.fwe = 4'b0110; o.res_we = 1'b1; end
            OP_BTST: begin o.res = a & b; o.fwe = 4'b0110; end
            OP_CPL:  begin
                o.res = a ^ {DATA_W{1'b1}};
                o.c   = 1'b1;
                o.fwe = 4'b0111;
                o.res_we = 1'b1;
            end
            OP_SWAP: begin
                o.res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
                o.fwe = 4'b0110;
                o.res_we = 1'b1;
            end
            OP_TST:  begin o.res = a; o.fwe = 4'b0110; end
            OP_CLR:  begin o.res = '0; o.fwe = 4'b0110; o.res_we = 1'b1; end
            default: o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output unit_out_t         o
);
    always_comb begin
        o = '0;
        unique case (op)
            OP_SLL: begin o.res = {a[DATA_W-2:0], 1'b0};        o.c = a[DATA_W-1]; end
            OP_SRL: begin o.res = {1'b0, a[DATA_W-1:1]};        o.c = a[0];        end
            OP_SRA: begin o.res = {a[DATA_W-1], a[DATA_W-1:1]}; o.c = a[0];        end
            OP_RLC: begin o.res = {a[DATA_W-2:0], cin};         o.c = a[DATA_W-1]; end
            OP_RRC: begin o.res = {cin, a[DATA_W-1:1]};         o.c = a[0];        end
            default: o = '0;
        endcase
        if (op inside {OP_SLL, OP_SRL, OP_SRA, OP_RLC, OP_RRC}) begin
            o.fwe    = 4'b0111;
            o.res_we = 1'b1;
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLG_W-1:0]  flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              res_we_o,
    output logic              hi_we_o,
    output logic [FLG_W-1:0]  flags_o,
    output logic [FLG_W-1:0]  flag_we_o
);
    localparam int N_UNITS = 3;

    unit_out_t u_out [N_UNITS];
    unit_out_t merged;
    logic [FLG_W-1:0] new_flags;
    logic [FLG_W-1:0] next_flags;
    logic             primed_q;

    alu8_arith u_arith (.op(op_i), .a(opa_i), .b(opb_i), .cin(flags_i[F_C]), .o(u_out[0]));
    alu8_logic u_logic (.op(op_i), .a(opa_i), .b(opb_i), .o(u_out[1]));
    alu8_shift u_shift (.op(op_i), .a(opa_i), .cin(flags_i[F_C]), .o(u_out[2]));

    // units are zero outside their own codes, so an OR selects the active one
    always_comb begin
        merged = '0;
        for (int k = 0; k < N_UNITS; k++) begin
            merged = merged | u_out[k];
        end
    end

    always_comb begin
        new_flags[F_H] = merged.h;
        new_flags[F_N] = merged.res[DATA_W-1];
        new_flags[F_Z] = (merged.res == '0);
        new_flags[F_C] = merged.c;
    end

    genvar g;
    generate
        for (g = 0; g < FLG_W; g++) begin : g_flag_mux
            assign next_flags[g] = merged.fwe[g] ? new_flags[g] : flags_i[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o     <= '0;
            hi_o      <= '0;
            res_we_o  <= 1'b0;
            hi_we_o   <= 1'b0;
            flags_o   <= '0;
            flag_we_o <= '0;
            primed_q  <= 1'b0;
        end else begin
            res_o     <= merged.res;
            hi_o      <= merged.hi;
            res_we_o  <= merged.res_we;
            hi_we_o   <= merged.hi_we;
            flags_o   <= next_flags;
            flag_we_o <= merged.fwe;
            primed_q  <= 1'b1;
        end
    end

    // R4: Z and N follow the result whenever they are written
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o[F_Z] |-> (flags_o[F_Z] == (res_o == '0)));
    a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o[F_N] |-> (flags_o[F_N] == res_o[DATA_W-1]));
    // R11: high byte only with a multiply-shaped flag update, H and C cleared
    a_r11_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we_o |-> (flag_we_o == 4'b1001 && flags_o[F_H] == 1'b0 && flags_o[F_C] == 1'b0 && res_we_o));
    // R13: unwritten flags pass through from the previous cycle's input
    a_r13_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !flag_we_o[F_H]) |-> (flags_o[F_H] == $past(flags_i[F_H])));
    // R3: compare never asks for the result to be stored
    a_r3_cmp_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op_i) == OP_CMP) |-> !res_we_o);
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    typedef struct packed {
        logic [7:0] res;
        logic [7:0] hi;
        logic       rwe;
        logic       hwe;
        logic [3:0] fl;
        logic [3:0] fwe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic [3:0] fin = '0;
    logic [7:0] res, hi;
    logic       rwe, hwe;
    logic [3:0] fl, fwe;

    int checks = 0;
    int fails  = 0;
    exp_t  q_exp[$];
    string q_tag[$];
    bit    drive_done = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b), .flags_i(fin),
        .res_o(res), .hi_o(hi), .res_we_o(rwe), .hi_we_o(hwe),
        .flags_o(fl), .flag_we_o(fwe)
    );

    function automatic string tag_of(input int code);
        if (code <= 1) return "R2";
        if (code <= 4) return "R3";
        if (code <= 8) return "R5";
        if (code <= 10) return "R6";
        if (code <= 12) return "R7";
        if (code <= 15) return "R8";
        if (code <= 17) return "R9";
        if (code <= 20) return "R10";
        if (code == 21) return "R11";
        return "R12";
    endfunction

    // bench model, flags ordered H N Z C
    function automatic exp_t model(input int code, input int x, input int y, input logic [3:0] f);
        exp_t e;
        int r, t;
        bit h, c, wh, wn, wz, wc;
        int ci;
        ci = f[0];
        e = '0; r = 0; h = 0; c = 0; wh = 0; wn = 1; wz = 1; wc = 0;
        e.rwe = 1;
        case (code)
            0, 1: begin
                t = (code == 1) ? ci : 0;
                r = x + y + t; c = (r > 255); h = ((x % 16) + (y % 16) + t) > 15;
                wh = 1; wc = 1;
            end
            2, 3, 4: begin
                t = (code == 3) ? ci : 0;
                r = x - y - t; c = (r < 0); wc = 1;
                if (code == 4) e.rwe = 0;
            end
            5: r = x & y;
            6: r = x | y;
            7: r = x ^ y;
            8: begin r = x & y; e.rwe = 0; end
            9: begin r = 255 - x; c = 1; wc = 1; end
            10: begin r = 256 - x; c = (x != 0); wc = 1; end
            11: r = x + 1;
            12: r = x - 1;
            13: begin r = x * 2; c = x >= 128; wc = 1; end
            14: begin r = x / 2; c = x % 2; wc = 1; end
            15: begin r = x / 2 + (x >= 128 ? 128 : 0); c = x % 2; wc = 1; end
            16: begin r = x * 2 + ci; c = x >= 128; wc = 1; end
            17: begin r = x / 2 + ci * 128; c = x % 2; wc = 1; end
            18: r = (x % 16) * 16 + x / 16;
            19: begin r = x; e.rwe = 0; end
            20: r = 0;
            21: begin
                t = x * y; r = t; e.hi = t / 256; e.hwe = 1;
                wh = 1; wc = 1; wn = 0; wz = 0; h = 0; c = 0;
            end
            default: begin r = 0; e.rwe = 0; wn = 0; wz = 0; end
        endcase
        r = ((r % 256) + 256) % 256;
        e.res = r[7:0];
        e.fwe = {wh, wn, wz, wc};
        e.fl[3] = wh ? h : f[3];
        e.fl[2] = wn ? (r >= 128) : f[2];
        e.fl[1] = wz ? (r == 0) : f[1];
        e.fl[0] = wc ? c : f[0];
        return e;
    endfunction

    task automatic drive(input int code, input int x, input int y, input logic [3:0] f);
        @(negedge clk);
        op = code[4:0]; a = x[7:0]; b = y[7:0]; fin = f;
        q_exp.push_back(model(code, x, y, f));
        q_tag.push_back(tag_of(code));
    endtask

    // monitor: result due one rising edge after the driving falling edge
    initial begin
        exp_t e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if ({res, hi, rwe, hwe, fl, fwe} !== e) begin
                    fails++;
                    $display("FAIL %s R1 actual res=%h hi=%h rwe=%b hwe=%b fl=%b fwe=%b expected res=%h hi=%h rwe=%b hwe=%b fl=%b fwe=%b",
                             t, res, hi, rwe, hwe, fl, fwe, e.res, e.hi, e.rwe, e.hwe, e.fl, e.fwe);
                end
            end
        end
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        fin = 4'b1111; op = 5'd0; a = 8'hFF; b = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({res, hi, rwe, hwe, fl, fwe} !== '0) begin
            fails++;
            $display("FAIL R1 reset actual %h expected 0", {res, hi, rwe, hwe, fl, fwe});
        end
        rst_n = 1'b1;
        // R2 corners: half carry, full wrap, carry-in
        drive(0, 8'h0F, 8'h01, 4'b0000);
        drive(0, 8'hFF, 8'h01, 4'b0000);
        drive(1, 8'h7F, 8'h00, 4'b0001);
        drive(1, 8'h10, 8'h20, 4'b1110);
        // R3 borrow corners and compare
        drive(2, 8'h00, 8'h01, 4'b0000);
        drive(3, 8'h00, 8'h00, 4'b0001);
        drive(3, 8'h05, 8'h03, 4'b1000);
        drive(4, 8'h42, 8'h42, 4'b1001);
        // R5 logic and bit test
        drive(5, 8'hF0, 8'h0F, 4'b1001);
        drive(6, 8'h80, 8'h01, 4'b0000);
        drive(7, 8'hAA, 8'hAA, 4'b1000);
        drive(8, 8'h81, 8'h80, 4'b0001);
        // R6 complement and negate
        drive(9, 8'h00, 8'h00, 4'b0000);
        drive(10, 8'h00, 8'h00, 4'b0001);
        drive(10, 8'h80, 8'h00, 4'b0000);
        drive(10, 8'h01, 8'h00, 4'b1000);
        // R7 wraps
        drive(11, 8'hFF, 8'h00, 4'b0001);
        drive(12, 8'h00, 8'h00, 4'b1000);
        // R8 shifts
        drive(13, 8'h81, 8'h00, 4'b0000);
        drive(14, 8'h01, 8'h00, 4'b0000);
        drive(15, 8'h81, 8'h00, 4'b0000);
        // R9 rotates through carry
        drive(16, 8'h80, 8'h00, 4'b0001);
        drive(17, 8'h01, 8'h00, 4'b0001);
        drive(17, 8'h00, 8'h00, 4'b0000);
        // R10 swap, test, clear
        drive(18, 8'h3C, 8'h00, 4'b0000);
        drive(19, 8'h00, 8'h00, 4'b1101);
        drive(20, 8'h55, 8'h00, 4'b1101);
        // R11 multiply corners
        drive(21, 8'hFF, 8'hFF, 4'b1111);
        drive(21, 8'h00, 8'h37, 4'b0110);
        // R12 unassigned codes, R13 pass-through
        drive(22, 8'h12, 8'h34, 4'b1010);
        drive(31, 8'hFF, 8'hFF, 4'b0101);
        // sweep every code with pseudo-random operands
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(i % 32, lf[7:0], lf[15:8], lf[3:0] ^ lf[11:8]);
        end
        @(negedge clk);
        op = 5'd31;
        @(posedge clk);
        #4;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule